// File: doc/BRIEF.md
# Module-Tagged TLB Access Checker

A small fully associative translation buffer whose entries each carry a module tag beside the virtual page number, the physical page number and a read/write/execute mask. A context register holds the module ID of the code now executing; module ID zero stands for ordinary unprotected software and is the value after reset. A lookup translates only when a valid entry holds the page, the entry's tag equals the context ID, and the mask grants the access kind. A tag mismatch or a forbidden access is reported as a violation, and lookups then stall until a supervisor resolves it.

Lookups use a valid/ready handshake. `req_ready` drops while a violation is pending, and the requester must hold its request until it is accepted. The result comes back as a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take it in that cycle. The supervisor refills entries, loads the context ID, and clears the whole table. It resolves a pending violation either by retagging the faulting entry with the current context ID (a legally shared page) or by dismissing it.

Top module: `mtag_tlb`

## Requirements
- R1: After reset the context ID is 0, every entry is invalid, no violation is pending, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) produces exactly one `rsp_valid` pulse in the following cycle, carrying that request's result. No response appears otherwise.
- R3: When a valid entry's page matches, its tag equals the context ID and the mask grants the access, the response has hit=1, the entry's physical page, violation=0 and cause 0.
- R4: A matching entry whose tag differs from the context ID gives hit=0, violation=1 and cause 1. The tag is checked before the mask, so cause 1 is reported even when the mask would also refuse.
- R5: Mask bit 0 grants read, bit 1 write and bit 2 execute. The access kind is encoded 0 = read, 1 = write, 2 = execute, and kind 3 is always refused. A refused access on a tag match gives hit=0, violation=1 and cause 2.
- R6: A page found in no valid entry gives hit=0, violation=0 and cause 3, and does not stall the port.
- R7: After a violating response, `req_ready` stays 0, and offered requests are neither accepted nor answered, until a retag or dismiss strobe. The strobe makes `req_ready` 1 again from the next cycle.
- R8: A retag strobe while a violation is pending overwrites the faulting entry's tag with the current context ID, so a retry of the same access hits. A retag strobe with nothing pending changes no entry.
- R9: A dismiss strobe clears the pending violation and leaves the entry unchanged, so a retry faults again.
- R10: `sup_ctx_we` loads `sup_ctx_id` into the context register, shown on `cur_mid` from the next cycle. A lookup accepted in the same cycle is judged against the old context ID.
- R11: A refill of a page that is not present writes the round-robin victim, which starts at entry 0 and steps through all 16 entries. A refill of a page already present overwrites that entry in place and does not advance the victim pointer.
- R12: A flush strobe invalidates every entry in one cycle. A refill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup request can be accepted (low while a violation is pending) |
| req_vpn | input | VPN_W | Virtual page number to look up |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Translation granted |
| rsp_ppn | output | PPN_W | Physical page number on a hit, zero otherwise |
| rsp_viol | output | 1 | Violation raised toward the supervisor |
| rsp_cause | output | 2 | 0 none, 1 module mismatch, 2 permission, 3 miss |
| fill_valid | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_mid | input | MID_W | Refill module tag |
| fill_perm | input | 3 | Refill permission mask {x,w,r} |
| sup_ctx_we | input | 1 | Load the context ID |
| sup_ctx_id | input | MID_W | New context ID |
| sup_retag | input | 1 | Retag the faulting entry with the context ID and release the stall |
| sup_dismiss | input | 1 | Release the stall without changing any entry |
| sup_flush | input | 1 | Invalidate all entries |
| cur_mid | output | MID_W | Current context ID |

## Verification
Every lookup result is due in the cycle right after the edge that accepts the request. The supervisor's actions (context load, retag, dismiss, flush, refill) take effect at the next edge and are seen by the first lookup accepted after it. The bench drives all inputs on falling edges and samples on falling edges, so a response is always compared one half-cycle after the edge that produced it. Expected responses go into a queue when a request is driven. A monitor pops one entry for each `rsp_valid` pulse, so a missing, extra or late response is reported as a mismatch. Stall and context checks read `req_ready` and `cur_mid` on the falling edge after the strobe that should change them.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MID  = 2'd1,
    CAUSE_PERM = 2'd2,
    CAUSE_MISS = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_X = 2;
endpackage

// File: rtl/mtag_rr_ptr.sv
module mtag_rr_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/mtag_entry_array.sv
module mtag_entry_array
  import mtag_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int MID_W = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [MID_W-1:0]  lk_mid,
  output logic [PERM_W-1:0] lk_perm,
  input  logic [VPN_W-1:0]  fl_vpn,
  output logic              fl_hit,
  output logic [IDX_W-1:0]  fl_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [MID_W-1:0]  wr_mid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              rt_en,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [MID_W-1:0]  rt_mid,
  input  logic              flush
);
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;
  logic [PPN_W-1:0]   ppn_a  [ENTRIES];
  logic [MID_W-1:0]   mid_a  [ENTRIES];
  logic [PERM_W-1:0]  perm_a [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              v_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [MID_W-1:0]  mid_q;
    logic [PERM_W-1:0] perm_q;
    logic              sel_wr, sel_rt;

    assign sel_wr = wr_en && (wr_idx == IDX_W'(i));
    assign sel_rt = rt_en && (rt_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      v_q <= 1'b0;
      else if (flush)  v_q <= 1'b0;
      else if (sel_wr) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        vpn_q  <= fl_vpn;
        ppn_q  <= wr_ppn;
        perm_q <= wr_perm;
      end
      if (sel_wr)      mid_q <= wr_mid;
      else if (sel_rt) mid_q <= rt_mid;
    end

    assign lk_match[i] = v_q && (vpn_q == lk_vpn);
    assign fl_match[i] = v_q && (vpn_q == fl_vpn);
    assign ppn_a[i]  = ppn_q;
    assign mid_a[i]  = mid_q;
    assign perm_a[i] = perm_q;
  end

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx = IDX_W'(i);
      if (fl_match[i]) fl_idx = IDX_W'(i);
    end
  end

  assign lk_hit  = |lk_match;
  assign fl_hit  = |fl_match;
  assign lk_ppn  = ppn_a[lk_idx];
  assign lk_mid  = mid_a[lk_idx];
  assign lk_perm = perm_a[lk_idx];
endmodule

// File: rtl/mtag_classify.sv
module mtag_classify
  import mtag_pkg::*;
#(
  parameter int MID_W = 4
) (
  input  logic              found,
  input  logic [MID_W-1:0]  ent_mid,
  input  logic [MID_W-1:0]  ctx_mid,
  input  logic [PERM_W-1:0] ent_perm,
  input  logic [1:0]        kind,
  output logic              grant,
  output logic              viol,
  output cause_e            cause
);
  logic perm_ok;

  always_comb begin
    unique case (acc_e'(kind))
      ACC_READ:  perm_ok = ent_perm[PERM_R];
      ACC_WRITE: perm_ok = ent_perm[PERM_WR];
      ACC_EXEC:  perm_ok = ent_perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase

    if (!found)                 cause = CAUSE_MISS;
    else if (ent_mid != ctx_mid) cause = CAUSE_MID;
    else if (!perm_ok)          cause = CAUSE_PERM;
    else                        cause = CAUSE_NONE;

    grant = (cause == CAUSE_NONE);
    viol  = (cause == CAUSE_MID) || (cause == CAUSE_PERM);
  end
endmodule

// File: rtl/mtag_tlb.sv
module mtag_tlb
  import mtag_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int MID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic              rsp_viol,
  output logic [1:0]        rsp_cause,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [MID_W-1:0]  fill_mid,
  input  logic [2:0]        fill_perm,
  input  logic              sup_ctx_we,
  input  logic [MID_W-1:0]  sup_ctx_id,
  input  logic              sup_retag,
  input  logic              sup_dismiss,
  input  logic              sup_flush,
  output logic [MID_W-1:0]  cur_mid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              pend_q;
  logic [IDX_W-1:0]  fault_idx_q;
  logic [MID_W-1:0]  ctx_q;
  logic              accept;
  logic              lk_hit, fl_hit;
  logic [IDX_W-1:0]  lk_idx, fl_idx, victim;
  logic [PPN_W-1:0]  lk_ppn;
  logic [MID_W-1:0]  lk_mid;
  logic [PERM_W-1:0] lk_perm;
  logic              wr_en;
  logic              grant, viol;
  cause_e            cause;

  assign req_ready = !pend_q;
  assign accept    = req_valid && req_ready;
  assign wr_en     = fill_valid && !sup_flush;
  assign cur_mid   = ctx_q;

  mtag_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .MID_W(MID_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_mid(lk_mid), .lk_perm(lk_perm),
    .fl_vpn(fill_vpn), .fl_hit(fl_hit), .fl_idx(fl_idx),
    .wr_en(wr_en), .wr_idx(fl_hit ? fl_idx : victim),
    .wr_ppn(fill_ppn), .wr_mid(fill_mid), .wr_perm(fill_perm),
    .rt_en(sup_retag && pend_q), .rt_idx(fault_idx_q), .rt_mid(ctx_q),
    .flush(sup_flush)
  );

  mtag_rr_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(wr_en && !fl_hit), .ptr(victim)
  );

  mtag_classify #(.MID_W(MID_W)) u_cls (
    .found(lk_hit), .ent_mid(lk_mid), .ctx_mid(ctx_q), .ent_perm(lk_perm),
    .kind(req_kind), .grant(grant), .viol(viol), .cause(cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q       <= '0;
      pend_q      <= 1'b0;
      fault_idx_q <= '0;
    end else begin
      if (sup_ctx_we) ctx_q <= sup_ctx_id;
      if (accept && viol) begin
        pend_q      <= 1'b1;
        fault_idx_q <= lk_idx;
      end else if (sup_retag || sup_dismiss) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_viol  <= 1'b0;
      rsp_cause <= 2'd0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit   <= grant;
        rsp_ppn   <= grant ? lk_ppn : '0;
        rsp_viol  <= viol;
        rsp_cause <= cause;
      end
    end
  end
endmodule

// File: rtl/mtag_tlb_chk.sv
module mtag_tlb_chk #(
  parameter int MID_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_viol,
  input logic [1:0]       rsp_cause,
  input logic             sup_retag,
  input logic             sup_dismiss,
  input logic             sup_ctx_we,
  input logic [MID_W-1:0] sup_ctx_id,
  input logic [MID_W-1:0] cur_mid
);
  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  assert_hit_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_cause == 2'd0 && !rsp_viol));

  assert_viol_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_viol) |-> (rsp_cause == 2'd1 || rsp_cause == 2'd2));

  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 2'd3) |-> (!rsp_viol && !rsp_hit));

  assert_stall_on_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_viol) |-> !req_ready);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !sup_retag && !sup_dismiss) |=> !req_ready);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (sup_retag || sup_dismiss)) |=> req_ready);

  assert_ctx_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sup_ctx_we |=> (cur_mid == $past(sup_ctx_id)));
endmodule

bind mtag_tlb mtag_tlb_chk #(.MID_W(MID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_viol(rsp_viol),
  .rsp_cause(rsp_cause), .sup_retag(sup_retag), .sup_dismiss(sup_dismiss),
  .sup_ctx_we(sup_ctx_we), .sup_ctx_id(sup_ctx_id), .cur_mid(cur_mid)
);

// File: tb/mtag_tlb_bench.sv
module mtag_tlb_bench;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int MID_W = 4;
  localparam time CYC = 20ns;
  localparam int EXP_W = PPN_W + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [1:0] req_kind = 2'd0;
  logic rsp_valid, rsp_hit, rsp_viol;
  logic [PPN_W-1:0] rsp_ppn;
  logic [1:0] rsp_cause;
  logic fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [MID_W-1:0] fill_mid = '0;
  logic [2:0] fill_perm = '0;
  logic sup_ctx_we = 1'b0, sup_retag = 1'b0, sup_dismiss = 1'b0, sup_flush = 1'b0;
  logic [MID_W-1:0] sup_ctx_id = '0;
  logic [MID_W-1:0] cur_mid;

  int n_chk = 0;
  int n_bad = 0;
  logic [EXP_W-1:0] exp_q[$];
  string tag_q[$];

  always #(CYC/2) clk = ~clk;

  mtag_tlb u_mtag_tlb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_kind(req_kind), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_viol(rsp_viol),
    .rsp_cause(rsp_cause), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_mid(fill_mid), .fill_perm(fill_perm),
    .sup_ctx_we(sup_ctx_we), .sup_ctx_id(sup_ctx_id), .sup_retag(sup_retag),
    .sup_dismiss(sup_dismiss), .sup_flush(sup_flush), .cur_mid(cur_mid)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: one queued expectation per response pulse
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected response", 1, 0);
      end else begin
        logic [EXP_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {rsp_hit, rsp_viol, rsp_cause, rsp_ppn}, e);
      end
    end
  end

  // drive one lookup; starts and ends on a falling edge
  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [1:0] kind,
                        input logic hit, input logic viol, input logic [1:0] cause,
                        input logic [PPN_W-1:0] ppn, input string tag);
    exp_q.push_back({hit, viol, cause, ppn});
    tag_q.push_back(tag);
    req_valid = 1'b1; req_vpn = vpn; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input logic [MID_W-1:0] mid, input logic [2:0] perm);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_mid = mid; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic set_ctx(input logic [MID_W-1:0] id);
    sup_ctx_we = 1'b1; sup_ctx_id = id;
    @(negedge clk);
    sup_ctx_we = 1'b0;
  endtask

  task automatic pulse_dismiss();
    sup_dismiss = 1'b1;
    @(negedge clk);
    sup_dismiss = 1'b0;
  endtask

  task automatic pulse_retag();
    sup_retag = 1'b1;
    @(negedge clk);
    sup_retag = 1'b0;
  endtask

  initial begin
    #(CYC * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cur_mid", cur_mid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after release", req_ready, 1);
    lookup(20'h5, 2'd0, 0, 0, 2'd3, '0, "R1 empty table miss");
    chk("R6 miss does not stall", req_ready, 1);

    // R10: context load
    set_ctx(4'd3);
    chk("R10 cur_mid", cur_mid, 3);

    // R3 / R5: permissions on a tag match
    fill(20'h10, 20'hA0, 4'd3, 3'b011);
    lookup(20'h10, 2'd0, 1, 0, 2'd0, 20'hA0, "R3 read hit");
    lookup(20'h10, 2'd1, 1, 0, 2'd0, 20'hA0, "R3 write hit");
    lookup(20'h10, 2'd2, 0, 1, 2'd2, '0, "R5 execute refused");
    chk("R7 stall after permission fault", req_ready, 0);
    pulse_dismiss();
    chk("R9 dismiss releases", req_ready, 1);
    lookup(20'h10, 2'd3, 0, 1, 2'd2, '0, "R5 reserved kind refused");
    pulse_dismiss();

    // R4 / R7 / R8: mismatch, stall, retag
    fill(20'h20, 20'hB0, 4'd5, 3'b111);
    lookup(20'h20, 2'd0, 0, 1, 2'd1, '0, "R4 module mismatch");
    req_valid = 1'b1; req_vpn = 20'h10; req_kind = 2'd0;
    @(negedge clk);
    chk("R7 ready low while pending", req_ready, 0);
    @(negedge clk);
    chk("R7 still low", req_ready, 0);
    req_valid = 1'b0;
    pulse_retag();
    chk("R7 release after retag", req_ready, 1);
    lookup(20'h20, 2'd2, 1, 0, 2'd0, 20'hB0, "R8 retry after retag hits");

    // R9: dismiss leaves entry unchanged
    fill(20'h30, 20'hC0, 4'd6, 3'b111);
    lookup(20'h30, 2'd0, 0, 1, 2'd1, '0, "R9 first fault");
    pulse_dismiss();
    lookup(20'h30, 2'd0, 0, 1, 2'd1, '0, "R9 retry still faults");
    pulse_dismiss();

    // R4 priority over permission; R8 retag ignored when idle
    fill(20'h40, 20'hD0, 4'd7, 3'b000);
    lookup(20'h40, 2'd0, 0, 1, 2'd1, '0, "R4 tag before mask");
    pulse_dismiss();
    pulse_retag();
    lookup(20'h40, 2'd0, 0, 1, 2'd1, '0, "R8 idle retag ignored");
    pulse_dismiss();

    // R10: lookup in same cycle as context write uses old ID
    exp_q.push_back({1'b1, 1'b0, 2'd0, 20'hB0});
    tag_q.push_back("R10 same-cycle lookup uses old ctx");
    req_valid = 1'b1; req_vpn = 20'h20; req_kind = 2'd0;
    sup_ctx_we = 1'b1; sup_ctx_id = 4'd5;
    @(negedge clk);
    req_valid = 1'b0; sup_ctx_we = 1'b0;
    chk("R10 cur_mid updated", cur_mid, 5);
    lookup(20'h20, 2'd0, 0, 1, 2'd1, '0, "R10 new ctx mismatches");
    pulse_dismiss();
    set_ctx(4'd3);

    // R11: in-place overwrite, then round-robin wrap
    fill(20'h10, 20'hE0, 4'd3, 3'b111);
    lookup(20'h10, 2'd2, 1, 0, 2'd0, 20'hE0, "R11 in-place overwrite");
    for (int i = 0; i < 12; i++) fill(20'h100 + VPN_W'(i), 20'h900 + PPN_W'(i), 4'd3, 3'b001);
    lookup(20'h10B, 2'd0, 1, 0, 2'd0, 20'h90B, "R11 entry 15 filled");
    lookup(20'h10, 2'd0, 1, 0, 2'd0, 20'hE0, "R11 entry 0 survives overwrite");
    fill(20'h200, 20'hF0, 4'd3, 3'b001);
    lookup(20'h10, 2'd0, 0, 0, 2'd3, '0, "R11 victim wrapped to entry 0");
    lookup(20'h200, 2'd0, 1, 0, 2'd0, 20'hF0, "R11 new entry hits");
    lookup(20'h20, 2'd0, 1, 0, 2'd0, 20'hB0, "R11 entry 1 kept");

    // R12: flush
    sup_flush = 1'b1;
    @(negedge clk);
    sup_flush = 1'b0;
    lookup(20'h20, 2'd0, 0, 0, 2'd3, '0, "R12 flushed entry misses");
    lookup(20'h200, 2'd0, 0, 0, 2'd3, '0, "R12 flushed entry misses");
    sup_flush = 1'b1;
    fill(20'h300, 20'h11, 4'd3, 3'b111);
    sup_flush = 1'b0;
    lookup(20'h300, 2'd0, 0, 0, 2'd3, '0, "R12 fill with flush discarded");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule